// File: doc/BRIEF.md
# Accumulator Pair with Byte/Word Add-with-Carry

This block holds the two working registers of an 8-bit processor core that can also handle 16-bit quantities. One is the primary accumulator, the other a temporary partner register. Loading the primary accumulator never simply discards its old contents. A word load shifts the whole old accumulator into the partner register before the new value lands. A byte load shifts only the old low byte into the partner's low byte, and then replaces only the accumulator's low byte.

The same register pair feeds an add-with-carry datapath that works in either width. A word add sums the full accumulator, the full partner register and a carry input. A byte add sums only the two low bytes and the carry input, and leaves the accumulator's upper byte alone. In both widths the carry out of the selected width is registered as a result flag. The core's sequencer drives one load request or one operation request per cycle. If it drives both in the same cycle, the load wins.

Top module: `acc_pair_unit`

## Requirements
- R1: While reset is asserted and right after it, the accumulator (`acc_q`), the partner register (`tmp_q`) and `carry_out` are all zero.
- R2: A word load (`ld_en`=1, `ld_word`=1) makes `acc_q` equal to `ld_data` and `tmp_q` equal to the old `acc_q` after the clock edge.
- R3: A byte load (`ld_en`=1, `ld_word`=0) writes `ld_data` bits 7:0 into `acc_q` bits 7:0 and copies the old `acc_q` bits 7:0 into `tmp_q` bits 7:0. Bits 15:8 of both `acc_q` and `tmp_q` keep their values.
- R4: A word add (`op_en`=1, `op_word`=1, no load) sets `acc_q` to (`acc_q` + `tmp_q` + `carry_in`) mod 2^16 and `carry_out` to bit 16 of that sum, and leaves `tmp_q` as it was. For example, 1234h + 5678h + 1 gives 68ADh with carry 0.
- R5: A byte add (`op_en`=1, `op_word`=0, no load) sets `acc_q` bits 7:0 to the low 8 bits of `acc_q`[7:0] + `tmp_q`[7:0] + `carry_in` and `carry_out` to bit 8 of that sum. `acc_q` bits 15:8 and all of `tmp_q` keep their values, and no carry reaches bit 8 of `acc_q`. For example, A=1234h, T=5678h, C=1 gives 12ADh.
- R6: When `ld_en` and `op_en` are both high in one cycle, only the load takes effect (R2/R3), and `carry_out` keeps its value.
- R7: With `ld_en`=0 and `op_en`=0 the registers and `carry_out` hold, whatever `ld_data`, `carry_in` and the width selects are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load request for the accumulator |
| ld_word | input | 1 | Load width: 1 = word, 0 = byte |
| ld_data | input | 16 | Load value (byte loads use bits 7:0) |
| op_en | input | 1 | Add-with-carry request |
| op_word | input | 1 | Operation width: 1 = word, 0 = byte |
| carry_in | input | 1 | Carry into the add |
| carry_out | output | 1 | Registered carry out of the last add |
| acc_q | output | 16 | Accumulator contents |
| tmp_q | output | 16 | Partner register contents |

## Verification
The byte add is swept over every low-byte accumulator value against a strided set of partner low bytes and both carry values, with varied upper bytes. This shows whether the carry is cut at the byte boundary and whether the upper bytes are kept. The word add is swept over operand pairs that cross both byte and word overflow, which separates a correct carry ripple into the upper byte from a byte-only sum. Directed sequences cover word and byte loads over distinct patterns, to see which lanes move into the partner register. They also cover load-plus-add collisions and idle cycles with the data and carry inputs still toggling, to show that those inputs have no effect.

// File: rtl/acc_pair_pkg.sv
package acc_pair_pkg;

   typedef enum logic {
      WIDTH_BYTE = 1'b0,
      WIDTH_WORD = 1'b1
   } width_e;

   typedef enum logic [1:0] {
      NXT_HOLD = 2'd0,
      NXT_LOAD = 2'd1,
      NXT_OP   = 2'd2
   } next_src_e;

   function automatic next_src_e pick_source(input logic ld, input logic op);
      if (ld)
         return NXT_LOAD;
      else if (op)
         return NXT_OP;
      else
         return NXT_HOLD;
   endfunction

endpackage

// File: rtl/acc_carry_chain.sv
module acc_carry_chain #(
   parameter int BYTE_W = 8,
   parameter bit RIPPLE = 1'b0,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic [WORD_W-1:0] a_in,
   input  logic [WORD_W-1:0] b_in,
   input  logic              c_in,
   output logic [WORD_W-1:0] sum_out,
   output logic              c_byte,
   output logic              c_word
);

   if (BYTE_W < 2) begin : g_bad_width
      $error("acc_carry_chain: BYTE_W must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      logic [WORD_W:0] chain;
      always_comb begin
         chain    = '0;
         chain[0] = c_in;
         sum_out  = '0;
         for (int i = 0; i < WORD_W; i++) begin
            sum_out[i]  = a_in[i] ^ b_in[i] ^ chain[i];
            chain[i+1]  = (a_in[i] & b_in[i]) | (chain[i] & (a_in[i] ^ b_in[i]));
         end
      end
      assign c_byte = chain[BYTE_W];
      assign c_word = chain[WORD_W];
   end else begin : g_split
      logic [BYTE_W:0] lo_sum;
      logic [BYTE_W:0] hi_sum;
      assign lo_sum = {1'b0, a_in[BYTE_W-1:0]} + {1'b0, b_in[BYTE_W-1:0]}
                    + {{BYTE_W{1'b0}}, c_in};
      assign hi_sum = {1'b0, a_in[WORD_W-1:BYTE_W]} + {1'b0, b_in[WORD_W-1:BYTE_W]}
                    + {{BYTE_W{1'b0}}, lo_sum[BYTE_W]};
      assign sum_out = {hi_sum[BYTE_W-1:0], lo_sum[BYTE_W-1:0]};
      assign c_byte  = lo_sum[BYTE_W];
      assign c_word  = hi_sum[BYTE_W];
   end

endmodule

// File: rtl/acc_load_path.sv
module acc_load_path #(
   parameter int BYTE_W = 8,
   localparam int LANES  = 2,
   localparam int WORD_W = LANES * BYTE_W
) (
   input  logic [WORD_W-1:0] acc_cur,
   input  logic [WORD_W-1:0] tmp_cur,
   input  logic [WORD_W-1:0] ld_data,
   input  logic              ld_word,
   output logic [WORD_W-1:0] acc_ld,
   output logic [WORD_W-1:0] tmp_ld
);

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      localparam int LO = ln * BYTE_W;
      logic lane_take;
      if (ln == 0) begin : g_low
         assign lane_take = 1'b1;
      end else begin : g_high
         assign lane_take = ld_word;
      end
      assign acc_ld[LO +: BYTE_W] = lane_take ? ld_data[LO +: BYTE_W] : acc_cur[LO +: BYTE_W];
      assign tmp_ld[LO +: BYTE_W] = lane_take ? acc_cur[LO +: BYTE_W] : tmp_cur[LO +: BYTE_W];
   end

endmodule

// File: rtl/acc_op_path.sv
module acc_op_path #(
   parameter int BYTE_W = 8,
   parameter bit RIPPLE = 1'b0,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic [WORD_W-1:0] acc_cur,
   input  logic [WORD_W-1:0] tmp_cur,
   input  logic              carry_in,
   input  logic              op_word,
   output logic [WORD_W-1:0] acc_op,
   output logic              carry_op
);

   logic [WORD_W-1:0] raw_sum;
   logic              cy_byte;
   logic              cy_word;

   acc_carry_chain #(.BYTE_W(BYTE_W), .RIPPLE(RIPPLE)) i_chain (
      .a_in    (acc_cur),
      .b_in    (tmp_cur),
      .c_in    (carry_in),
      .sum_out (raw_sum),
      .c_byte  (cy_byte),
      .c_word  (cy_word)
   );

   always_comb begin
      if (op_word == acc_pair_pkg::WIDTH_WORD) begin
         acc_op   = raw_sum;
         carry_op = cy_word;
      end else begin
         acc_op   = {acc_cur[WORD_W-1:BYTE_W], raw_sum[BYTE_W-1:0]};
         carry_op = cy_byte;
      end
   end

endmodule

// File: rtl/acc_pair_regs.sv
module acc_pair_regs #(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              op_en,
   input  logic [WORD_W-1:0] acc_ld,
   input  logic [WORD_W-1:0] tmp_ld,
   input  logic [WORD_W-1:0] acc_op,
   input  logic              carry_op,
   output logic [WORD_W-1:0] acc_r,
   output logic [WORD_W-1:0] tmp_r,
   output logic              carry_r
);
   import acc_pair_pkg::*;

   next_src_e src;
   assign src = pick_source(ld_en, op_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_r   <= '0;
         tmp_r   <= '0;
         carry_r <= 1'b0;
      end else begin
         unique case (src)
            NXT_LOAD: begin
               acc_r <= acc_ld;
               tmp_r <= tmp_ld;
            end
            NXT_OP: begin
               acc_r   <= acc_op;
               carry_r <= carry_op;
            end
            default: ;
         endcase
      end
   end

   // R6: the carry flag only moves on a cycle with an add and no load
   assert_carry_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en || !op_en) |=> $stable(carry_r));

   // R4/R5: the partner register never changes on an add-only cycle
   assert_tmp_kept_on_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && !ld_en) |=> $stable(tmp_r));

endmodule

// File: rtl/acc_pair_unit.sv
module acc_pair_unit #(
   parameter int BYTE_W = 8,
   parameter bit RIPPLE = 1'b0,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              ld_word,
   input  logic [WORD_W-1:0] ld_data,
   input  logic              op_en,
   input  logic              op_word,
   input  logic              carry_in,
   output logic              carry_out,
   output logic [WORD_W-1:0] acc_q,
   output logic [WORD_W-1:0] tmp_q
);

   if (BYTE_W < 2 || BYTE_W > 32) begin : g_bad_cfg
      $error("acc_pair_unit: BYTE_W out of supported range 2..32");
   end

   logic [WORD_W-1:0] acc_ld;
   logic [WORD_W-1:0] tmp_ld;
   logic [WORD_W-1:0] acc_op;
   logic              carry_op;

   acc_load_path #(.BYTE_W(BYTE_W)) i_load (
      .acc_cur (acc_q),
      .tmp_cur (tmp_q),
      .ld_data (ld_data),
      .ld_word (ld_word),
      .acc_ld  (acc_ld),
      .tmp_ld  (tmp_ld)
   );

   acc_op_path #(.BYTE_W(BYTE_W), .RIPPLE(RIPPLE)) i_op (
      .acc_cur  (acc_q),
      .tmp_cur  (tmp_q),
      .carry_in (carry_in),
      .op_word  (op_word),
      .acc_op   (acc_op),
      .carry_op (carry_op)
   );

   acc_pair_regs #(.BYTE_W(BYTE_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .op_en    (op_en),
      .acc_ld   (acc_ld),
      .tmp_ld   (tmp_ld),
      .acc_op   (acc_op),
      .carry_op (carry_op),
      .acc_r    (acc_q),
      .tmp_r    (tmp_q),
      .carry_r  (carry_out)
   );

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (acc_q == '0 && tmp_q == '0 && !carry_out));

   assert_word_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_word) |=> (acc_q == $past(ld_data) && tmp_q == $past(acc_q)));

   assert_byte_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !ld_word) |=>
         (acc_q == {$past(acc_q[WORD_W-1:BYTE_W]), $past(ld_data[BYTE_W-1:0])}
          && tmp_q == {$past(tmp_q[WORD_W-1:BYTE_W]), $past(acc_q[BYTE_W-1:0])}));

   assert_word_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && !ld_en && op_word) |=>
         ({carry_out, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(tmp_q)}
                                 + {{WORD_W{1'b0}}, $past(carry_in)})));

   assert_byte_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && !ld_en && !op_word) |=> $stable(acc_q[WORD_W-1:BYTE_W]));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !op_en) |=> ($stable(acc_q) && $stable(tmp_q) && $stable(carry_out)));

endmodule

// File: tb/test_acc_pair_unit.sv
module test_acc_pair_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic        ld_word = 1'b0;
   logic [15:0] ld_data = '0;
   logic        op_en = 1'b0;
   logic        op_word = 1'b0;
   logic        carry_in = 1'b0;
   logic        carry_out;
   logic [15:0] acc_q;
   logic [15:0] tmp_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   acc_pair_unit i_acc_pair_unit (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_word(ld_word), .ld_data(ld_data),
      .op_en(op_en), .op_word(op_word), .carry_in(carry_in),
      .carry_out(carry_out), .acc_q(acc_q), .tmp_q(tmp_q)
   );

   // compares {carry, acc, tmp}
   task automatic check(input string req, input logic [32:0] exp);
      logic [32:0] act;
      act = {carry_out, acc_q, tmp_q};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got c=%0b A=%h T=%h, expected c=%0b A=%h T=%h",
                  req, act[32], act[31:16], act[15:0], exp[32], exp[31:16], exp[15:0]);
      end
   endtask

   // one clock cycle of stimulus; returns at the next falling edge
   task automatic cyc(input logic l, input logic lw, input logic [15:0] d,
                      input logic o, input logic ow, input logic c);
      ld_en = l; ld_word = lw; ld_data = d; op_en = o; op_word = ow; carry_in = c;
      @(posedge clk);
      @(negedge clk);
      ld_en = 1'b0; op_en = 1'b0;
   endtask

   task automatic set_pair(input logic [15:0] a, input logic [15:0] t);
      cyc(1'b1, 1'b1, t, 1'b0, 1'b0, 1'b0);
      cyc(1'b1, 1'b1, a, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic        c_keep;
      logic [16:0] ws;
      logic [8:0]  bs;
      @(negedge clk);
      @(negedge clk);
      check("R1 in reset", {1'b0, 16'h0000, 16'h0000});
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {1'b0, 16'h0000, 16'h0000});

      // R2 word loads: old A moves to T
      cyc(1'b1, 1'b1, 16'h1111, 1'b0, 1'b0, 1'b0);
      check("R2 first word load", {1'b0, 16'h1111, 16'h0000});
      cyc(1'b1, 1'b1, 16'hABCD, 1'b0, 1'b0, 1'b0);
      check("R2 second word load", {1'b0, 16'hABCD, 16'h1111});

      // R3 byte load: only low lanes move
      cyc(1'b1, 1'b0, 16'h775E, 1'b0, 1'b0, 1'b0);
      check("R3 byte load", {1'b0, 16'hAB5E, 16'h11CD});
      cyc(1'b1, 1'b0, 16'hFF00, 1'b0, 1'b0, 1'b0);
      check("R3 second byte load", {1'b0, 16'hAB00, 16'h115E});

      // R4 word add, example value
      set_pair(16'h1234, 16'h5678);
      cyc(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b1);
      check("R4 word add 1234+5678+1", {1'b0, 16'h68AD, 16'h5678});
      // R4 word overflow
      set_pair(16'hFFFF, 16'h0001);
      cyc(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0);
      check("R4 word overflow", {1'b1, 16'h0000, 16'h0001});

      // R5 byte add, example value
      set_pair(16'h1234, 16'h5678);
      cyc(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
      check("R5 byte add example", {1'b0, 16'h12AD, 16'h5678});
      // R5 byte overflow does not enter upper byte
      set_pair(16'h12FF, 16'h0001);
      cyc(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
      check("R5 byte overflow", {1'b1, 16'h1200, 16'h0001});

      // R7 idle with toggling inputs: carry is 1 now
      cyc(1'b0, 1'b1, 16'hDEAD, 1'b0, 1'b1, 1'b0);
      check("R7 idle hold", {1'b1, 16'h1200, 16'h0001});
      cyc(1'b0, 1'b0, 16'hBEEF, 1'b0, 1'b0, 1'b1);
      check("R7 idle hold second", {1'b1, 16'h1200, 16'h0001});

      // R6 load wins over add, carry kept at 1
      cyc(1'b1, 1'b1, 16'h4321, 1'b1, 1'b1, 1'b0);
      check("R6 word load with add", {1'b1, 16'h4321, 16'h1200});
      cyc(1'b1, 1'b0, 16'h0099, 1'b1, 1'b0, 1'b1);
      check("R6 byte load with add", {1'b1, 16'h4399, 16'h1221});

      // R5 sweep: every A low byte, strided T low byte, both carries
      for (int a = 0; a < 256; a++) begin
         for (int t = 0; t < 256; t += 5) begin
            for (int c = 0; c < 2; c++) begin
               logic [15:0] av, tv;
               av = {8'(a * 3 + 7), 8'(a)};
               tv = {8'(t ^ 8'h96), 8'(t)};
               set_pair(av, tv);
               cyc(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'(c));
               bs = {1'b0, av[7:0]} + {1'b0, tv[7:0]} + 9'(c);
               check("R5 byte sweep", {bs[8], av[15:8], bs[7:0], tv});
            end
         end
      end

      // R4 sweep: varied word operands, both carries
      for (int i = 0; i < 256; i++) begin
         for (int j = 0; j < 16; j++) begin
            for (int c = 0; c < 2; c++) begin
               logic [15:0] av, tv;
               av = 16'(i * 16'h0101) ^ 16'(j * 16'h1000);
               tv = 16'(j * 16'h1111) + 16'(i * 3);
               set_pair(av, tv);
               cyc(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'(c));
               ws = {1'b0, av} + {1'b0, tv} + 17'(c);
               check("R4 word sweep", {ws[16], ws[15:0], tv});
            end
         end
      end

      // R6 carry stays after sweep on a load-only cycle
      c_keep = carry_out;
      cyc(1'b1, 1'b1, 16'h0F0F, 1'b1, 1'b1, ~c_keep);
      check("R6 carry after collision", {c_keep, 16'h0F0F, acc_q === 16'h0F0F ? tmp_q : 16'hxxxx});

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule